// File: doc/BRIEF.md
# Power-Gating Domain Sequencer

This block brings one power-gated region of logic up and down in a safe order. A single request pulse gives the wanted direction. The sequencer then drives the region's controls one step at a time. These controls are two power switches, clock disable, isolation, an active-low reset, a field of SRAM power-down lines and a bus-fence request.

Between steps the sequencer waits for acknowledges from the region. Two power-good lines report the switch state, and a field of SRAM acknowledges reports the memory state. Each wait is limited by a cycle count. If a limit runs out, the sequence stops where it is and reports an error until software clears it. After the clear, the block returns to the idle state it started the sequence from, so the same request can be retried.

Integration is simple. Tie the control outputs to the power switches, isolation cells, clock gates and SRAM macros. Feed the power-good and SRAM acknowledge lines back in. Pulse `req_vld` with `req_on` set to the wanted direction.

Top module: `pwr_domain_seq`

## Requirements
- R1: After reset the outputs show a fully off domain. `ctl_o` = 5'b10010: bit 0 is the active-low reset, asserted low; bit 1 is isolation, set; bits 2 and 3 are the first and second switch, both off; bit 4 is clock disable, set. In addition `sram_pdn_o` = PDN_MASK, `bus_prot_o` = PROT_MASK, `state_o` = 0 (off idle), and `busy_o`, `err_o` and `done_o` are all 0.
- R2: The power-up order is fixed:
  1. Set bit 2.
  2. Set bit 3.
  3. Wait for power-good.
  4. Clear bit 4.
  5. Clear bit 1.
  6. Set bit 0.
  7. Clear the PDN_MASK bits of `sram_pdn_o`.
  8. Wait for the SRAM acknowledge.
  9. Clear `bus_prot_o`.
- R3: The power-down order is fixed:
  1. Set `bus_prot_o` to PROT_MASK.
  2. Set the PDN_MASK bits of `sram_pdn_o`.
  3. Wait for the SRAM acknowledge.
  4. Set bit 1.
  5. Clear bit 0.
  6. Set bit 4.
  7. Clear bit 2.
  8. Clear bit 3.
  9. Wait for power-off.
- R4: Power counts as good only when `pwr_ack_a` and `pwr_ack_b` are both 1, and as off only when both are 0. A mismatch between the two satisfies neither wait.
- R5: The SRAM waits look only at the `sram_ack` bits selected by ACK_MASK. Power-up waits for all of them to be 0, and power-down waits for all of them to be 1. When ACK_MASK is zero, both waits are skipped.
- R6: When PROT_MASK is zero, the bus-fence steps are skipped and `bus_prot_o` stays 0.
- R7: A wait that lasts TIMEOUT_LIMIT cycles aborts the sequence. The block then enters the error state (`state_o` = 2) with `err_o` = 1, and every control output holds its value.
- R8: A `clr_err` pulse in the error state returns the block to the idle state the sequence started from: off idle (`state_o` = 0) after a failed power-up, or on idle (`state_o` = 1) after a failed power-down.
- R9: Some requests are ignored with no output change: a request while busy, a request while in the error state, and a request for the direction the domain is already idle in.
- R10: `busy_o` is 1 from the cycle after an accepted request until the sequence ends. On success, `done_o` pulses high for exactly one cycle as the block reaches on idle (`state_o` = 1) or off idle (`state_o` = 0).
- R11: Each output step is held for at least STEP_HOLD cycles before the next output change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_vld | input | 1 | Request strobe |
| req_on | input | 1 | Requested direction, 1 = power up |
| clr_err | input | 1 | Leave the error state |
| pwr_ack_a | input | 1 | Power-good from the first switch stage |
| pwr_ack_b | input | 1 | Power-good from the second switch stage |
| sram_ack | input | SRAM_W | SRAM power-down acknowledges |
| ctl_o | output | 5 | Reset_n, isolation, switch 1, switch 2, clock disable (bits 0 to 4) |
| sram_pdn_o | output | SRAM_W | SRAM power-down requests |
| bus_prot_o | output | PROT_W | Bus fence requests |
| done_o | output | 1 | One-cycle success pulse |
| busy_o | output | 1 | Sequence in progress |
| err_o | output | 1 | Stopped on a timeout |
| state_o | output | 5 | Current sequencer state code |

## Verification
The ordering assertions assume the acknowledges only follow the block's own outputs; an acknowledge that leads its request is never driven. The bench domain model respects this. It derives each acknowledge from the matching control output through a fixed delay, and can freeze that acknowledge at its last value to force a slow wait or a timeout. Request and clear pulses come one cycle wide at the falling edge, and the stuck inputs that provoke an error are released only after the error is cleared or before the limit is reached.

// File: rtl/pgs_pkg.sv
package pgs_pkg;

   localparam int CTL_W     = 5;
   localparam int CB_RSTN   = 0;
   localparam int CB_ISO    = 1;
   localparam int CB_SW1    = 2;
   localparam int CB_SW2    = 3;
   localparam int CB_CLKDIS = 4;

   localparam logic [CTL_W-1:0] CTL_RESET = 5'b10010;

   typedef enum logic [4:0] {
      ST_OFF    = 5'd0,
      ST_ON     = 5'd1,
      ST_ERR    = 5'd2,
      ST_U_SW1  = 5'd3,
      ST_U_SW2  = 5'd4,
      ST_U_PWT  = 5'd5,
      ST_U_CLK  = 5'd6,
      ST_U_ISO  = 5'd7,
      ST_U_RST  = 5'd8,
      ST_U_SRM  = 5'd9,
      ST_U_SWT  = 5'd10,
      ST_U_PRT  = 5'd11,
      ST_D_PRT  = 5'd12,
      ST_D_SRM  = 5'd13,
      ST_D_SWT  = 5'd14,
      ST_D_ISO  = 5'd15,
      ST_D_RST  = 5'd16,
      ST_D_CLK  = 5'd17,
      ST_D_SW1  = 5'd18,
      ST_D_SW2  = 5'd19,
      ST_D_PWT  = 5'd20
   } seq_state_t;

endpackage

// File: rtl/pgs_sync.sv
module pgs_sync #(
   parameter int             W       = 1,
   parameter int             STAGES  = 2,
   parameter logic [W-1:0]   RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   logic [W-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[0] <= RST_VAL;
      else        stg[0] <= d;
   end

   for (genvar i = 1; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) stg[i] <= RST_VAL;
         else        stg[i] <= stg[i-1];
      end
   end

   assign q = stg[STAGES-1];

endmodule

// File: rtl/pgs_cnt.sv
module pgs_cnt #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   output logic [W-1:0] cnt
);

   localparam logic [W-1:0] CNT_MAX = '1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt <= '0;
      else if (clr)            cnt <= '0;
      else if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
   end

endmodule

// File: rtl/pwr_domain_seq.sv
module pwr_domain_seq
   import pgs_pkg::*;
#(
   parameter int                SRAM_W        = 4,
   parameter logic [SRAM_W-1:0] PDN_MASK      = '1,
   parameter logic [SRAM_W-1:0] ACK_MASK      = '1,
   parameter int                PROT_W        = 2,
   parameter logic [PROT_W-1:0] PROT_MASK     = '1,
   parameter int                STEP_HOLD     = 1,
   parameter int                TIMEOUT_LIMIT = 1000,
   parameter int                SYNC_STAGES   = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_vld,
   input  logic              req_on,
   input  logic              clr_err,
   input  logic              pwr_ack_a,
   input  logic              pwr_ack_b,
   input  logic [SRAM_W-1:0] sram_ack,
   output logic [CTL_W-1:0]  ctl_o,
   output logic [SRAM_W-1:0] sram_pdn_o,
   output logic [PROT_W-1:0] bus_prot_o,
   output logic              done_o,
   output logic              busy_o,
   output logic              err_o,
   output logic [4:0]        state_o
);

   localparam int              CNT_W     = 16;
   localparam logic [CNT_W-1:0] HOLD_LAST = CNT_W'(STEP_HOLD - 1);
   localparam logic [CNT_W-1:0] TO_LAST   = CNT_W'(TIMEOUT_LIMIT - 1);
   localparam bit              HAS_ACK   = (ACK_MASK != '0);
   localparam bit              HAS_PROT  = (PROT_MASK != '0);
   localparam seq_state_t      UP_TAIL   = HAS_PROT ? ST_U_PRT : ST_ON;
   localparam seq_state_t      DN_HEAD   = HAS_PROT ? ST_D_PRT : ST_D_SRM;
   localparam seq_state_t      UP_AFTER_SRM = HAS_ACK ? ST_U_SWT : UP_TAIL;
   localparam seq_state_t      DN_AFTER_SRM = HAS_ACK ? ST_D_SWT : ST_D_ISO;

   // elaboration-time parameter checks
   if (STEP_HOLD < 1 || STEP_HOLD > 65535) begin : g_bad_hold
      $error("STEP_HOLD must lie in 1..65535");
   end
   if (TIMEOUT_LIMIT < 2 || TIMEOUT_LIMIT > 65535) begin : g_bad_timeout
      $error("TIMEOUT_LIMIT must lie in 2..65535");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (SRAM_W < 1 || PROT_W < 1) begin : g_bad_width
      $error("SRAM_W and PROT_W must be positive");
   end

   // acknowledge synchronizers
   logic [1:0]        pa_s;
   logic [SRAM_W-1:0] sa_s;

   pgs_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b00)) u_pwr_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({pwr_ack_b, pwr_ack_a}),
      .q     (pa_s)
   );

   pgs_sync #(.W(SRAM_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_sram_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (sram_ack),
      .q     (sa_s)
   );

   logic pwr_good, pwr_gone, sram_awake, sram_asleep;
   assign pwr_good    = pa_s[0] & pa_s[1];
   assign pwr_gone    = ~pa_s[0] & ~pa_s[1];
   assign sram_awake  = (sa_s & ACK_MASK) == '0;
   assign sram_asleep = (sa_s & ACK_MASK) == ACK_MASK;

   // state and step/timeout counter
   seq_state_t       st_q, st_d;
   logic [CNT_W-1:0] cnt;
   logic             st_chg, hold_ok, to_hit, idle_now, dir_up_q;

   assign st_chg = (st_d != st_q);

   pgs_cnt #(.W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (st_chg),
      .cnt   (cnt)
   );

   assign hold_ok  = (cnt == HOLD_LAST);
   assign to_hit   = (cnt == TO_LAST);
   assign idle_now = (st_q == ST_OFF) || (st_q == ST_ON) || (st_q == ST_ERR);

   always_comb begin
      st_d = st_q;
      case (st_q)
         ST_OFF:   if (req_vld && req_on)  st_d = ST_U_SW1;
         ST_ON:    if (req_vld && !req_on) st_d = DN_HEAD;
         ST_ERR:   if (clr_err)            st_d = dir_up_q ? ST_OFF : ST_ON;
         ST_U_SW1: if (hold_ok) st_d = ST_U_SW2;
         ST_U_SW2: if (hold_ok) st_d = ST_U_PWT;
         ST_U_PWT: begin
            if (pwr_good)    st_d = ST_U_CLK;
            else if (to_hit) st_d = ST_ERR;
         end
         ST_U_CLK: if (hold_ok) st_d = ST_U_ISO;
         ST_U_ISO: if (hold_ok) st_d = ST_U_RST;
         ST_U_RST: if (hold_ok) st_d = ST_U_SRM;
         ST_U_SRM: if (hold_ok) st_d = UP_AFTER_SRM;
         ST_U_SWT: begin
            if (sram_awake)  st_d = UP_TAIL;
            else if (to_hit) st_d = ST_ERR;
         end
         ST_U_PRT: if (hold_ok) st_d = ST_ON;
         ST_D_PRT: if (hold_ok) st_d = ST_D_SRM;
         ST_D_SRM: if (hold_ok) st_d = DN_AFTER_SRM;
         ST_D_SWT: begin
            if (sram_asleep) st_d = ST_D_ISO;
            else if (to_hit) st_d = ST_ERR;
         end
         ST_D_ISO: if (hold_ok) st_d = ST_D_RST;
         ST_D_RST: if (hold_ok) st_d = ST_D_CLK;
         ST_D_CLK: if (hold_ok) st_d = ST_D_SW1;
         ST_D_SW1: if (hold_ok) st_d = ST_D_SW2;
         ST_D_SW2: if (hold_ok) st_d = ST_D_PWT;
         ST_D_PWT: begin
            if (pwr_gone)    st_d = ST_OFF;
            else if (to_hit) st_d = ST_ERR;
         end
         default:  st_d = ST_ERR;
      endcase
   end

   // registered controls: each step state applies its change on entry
   logic [CTL_W-1:0]  ctl_q;
   logic [SRAM_W-1:0] pdn_q;
   logic [PROT_W-1:0] prot_q;
   logic              done_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q     <= ST_OFF;
         dir_up_q <= 1'b1;
         ctl_q    <= CTL_RESET;
         pdn_q    <= PDN_MASK;
         prot_q   <= PROT_MASK;
         done_q   <= 1'b0;
      end else begin
         st_q   <= st_d;
         done_q <= !idle_now && st_chg && ((st_d == ST_ON) || (st_d == ST_OFF));
         if (st_q == ST_OFF && st_chg) dir_up_q <= 1'b1;
         if (st_q == ST_ON  && st_chg) dir_up_q <= 1'b0;
         if (st_chg) begin
            case (st_d)
               ST_U_SW1: ctl_q[CB_SW1]    <= 1'b1;
               ST_U_SW2: ctl_q[CB_SW2]    <= 1'b1;
               ST_U_CLK: ctl_q[CB_CLKDIS] <= 1'b0;
               ST_U_ISO: ctl_q[CB_ISO]    <= 1'b0;
               ST_U_RST: ctl_q[CB_RSTN]   <= 1'b1;
               ST_U_SRM: pdn_q            <= pdn_q & ~PDN_MASK;
               ST_U_PRT: prot_q           <= prot_q & ~PROT_MASK;
               ST_D_PRT: prot_q           <= prot_q | PROT_MASK;
               ST_D_SRM: pdn_q            <= pdn_q | PDN_MASK;
               ST_D_ISO: ctl_q[CB_ISO]    <= 1'b1;
               ST_D_RST: ctl_q[CB_RSTN]   <= 1'b0;
               ST_D_CLK: ctl_q[CB_CLKDIS] <= 1'b1;
               ST_D_SW1: ctl_q[CB_SW1]    <= 1'b0;
               ST_D_SW2: ctl_q[CB_SW2]    <= 1'b0;
               default:  ;
            endcase
         end
      end
   end

   assign ctl_o      = ctl_q;
   assign sram_pdn_o = pdn_q;
   assign bus_prot_o = prot_q;
   assign done_o     = done_q;
   assign busy_o     = !idle_now;
   assign err_o      = (st_q == ST_ERR);
   assign state_o    = st_q;

endmodule

// File: rtl/pgs_chk.sv
module pgs_chk #(
   parameter int                SRAM_W    = 4,
   parameter logic [SRAM_W-1:0] PDN_MASK  = '1,
   parameter int                PROT_W    = 2,
   parameter logic [PROT_W-1:0] PROT_MASK = '1
) (
   input logic              clk,
   input logic              rst_n,
   input logic [4:0]        ctl_o,
   input logic [SRAM_W-1:0] sram_pdn_o,
   input logic [PROT_W-1:0] bus_prot_o,
   input logic              done_o,
   input logic              busy_o,
   input logic              err_o
);

   // R10: never busy and in error together
   a_r10_busy_err_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(busy_o && err_o));

   // R10: success indication lasts one cycle
   a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   // R10: success is reported only once idle
   a_r10_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (!busy_o && !err_o));

   // R2 / R3: isolation is off only while both switches are on
   a_r2_iso_needs_power: assert property (@(posedge clk) disable iff (!rst_n)
      !ctl_o[1] |-> (ctl_o[2] && ctl_o[3]));

   // R2 / R3: reset is released only with the clock running
   a_r2_rst_needs_clk: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_o[0] |-> !ctl_o[4]);

   // R3: SRAM is awake only while the domain reset is released
   a_r3_sram_needs_rst: assert property (@(posedge clk) disable iff (!rst_n)
      ((sram_pdn_o & PDN_MASK) != PDN_MASK) |-> ctl_o[0]);

   // R6: the bus fence opens only on a fully running domain
   a_r6_fence_last: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_prot_o != PROT_MASK) |-> (((sram_pdn_o & PDN_MASK) == '0) && ctl_o[0]));

   // R7: controls are frozen in the error state
   a_r7_err_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |=> ($stable(ctl_o) && $stable(sram_pdn_o) && $stable(bus_prot_o)));

endmodule

bind pwr_domain_seq pgs_chk #(
   .SRAM_W    (SRAM_W),
   .PDN_MASK  (PDN_MASK),
   .PROT_W    (PROT_W),
   .PROT_MASK (PROT_MASK)
) i_pgs_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .ctl_o      (ctl_o),
   .sram_pdn_o (sram_pdn_o),
   .bus_prot_o (bus_prot_o),
   .done_o     (done_o),
   .busy_o     (busy_o),
   .err_o      (err_o)
);

// File: tb/test_pwr_domain_seq.sv
module test_pwr_domain_seq;

   localparam int          HOLD    = 3;
   localparam int          TLIM    = 60;
   localparam logic [3:0]  AMASK   = 4'b0011;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   // main instance
   logic       req_vld = 1'b0, req_on = 1'b0, clr_err = 1'b0;
   logic       pa1 = 1'b0, pa2 = 1'b0;
   logic [3:0] sa = 4'b0000;
   logic [4:0] ctl;
   logic [3:0] pdn;
   logic [1:0] prot;
   logic       done, busy, err;
   logic [4:0] state;

   pwr_domain_seq #(
      .SRAM_W(4), .PDN_MASK(4'hF), .ACK_MASK(AMASK), .PROT_W(2), .PROT_MASK(2'b11),
      .STEP_HOLD(HOLD), .TIMEOUT_LIMIT(TLIM), .SYNC_STAGES(2)
   ) i_pwr_domain_seq (
      .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_on(req_on), .clr_err(clr_err),
      .pwr_ack_a(pa1), .pwr_ack_b(pa2), .sram_ack(sa),
      .ctl_o(ctl), .sram_pdn_o(pdn), .bus_prot_o(prot),
      .done_o(done), .busy_o(busy), .err_o(err), .state_o(state)
   );

   // second instance: no SRAM acknowledge, no bus fence
   logic       b_req_vld = 1'b0, b_req_on = 1'b0;
   logic [4:0] b_ctl;
   logic [3:0] b_pdn;
   logic [1:0] b_prot;
   logic       b_done, b_busy, b_err;
   logic [4:0] b_state;

   pwr_domain_seq #(
      .SRAM_W(4), .PDN_MASK(4'hF), .ACK_MASK(4'h0), .PROT_W(2), .PROT_MASK(2'b00)
   ) i_pwr_domain_seq_bare (
      .clk(clk), .rst_n(rst_n), .req_vld(b_req_vld), .req_on(b_req_on), .clr_err(1'b0),
      .pwr_ack_a(b_ctl[2]), .pwr_ack_b(b_ctl[3]), .sram_ack(4'hF),
      .ctl_o(b_ctl), .sram_pdn_o(b_pdn), .bus_prot_o(b_prot),
      .done_o(b_done), .busy_o(b_busy), .err_o(b_err), .state_o(b_state)
   );

   // domain model: delayed acknowledges, each can be frozen
   logic       p1_hold = 1'b0, p2_hold = 1'b0, s_hold = 1'b0;
   logic [2:0] p1_sh = '0;
   logic [4:0] p2_sh = '0;
   logic [3:0] s_sh [4] = '{default: 4'h0};

   always @(negedge clk) begin
      p1_sh <= {p1_sh[1:0], ctl[2]};
      p2_sh <= {p2_sh[3:0], ctl[3]};
      s_sh[0] <= pdn;
      for (int i = 1; i < 4; i++) s_sh[i] <= s_sh[i-1];
      if (!p1_hold) pa1 <= p1_sh[2];
      if (!p2_hold) pa2 <= p2_sh[4];
      if (!s_hold)  sa  <= s_sh[3] & AMASK;
   end

   // checking infrastructure
   int nchk = 0, nfail = 0;
   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h (cycle %0d)", req, act, exp, cyc);
      end
   endtask

   // scoreboard: expected snapshots {prot, pdn, ctl}
   logic [10:0] exp_q [$];
   logic [10:0] exp_cur = {2'b11, 4'hF, 5'b10010};

   function automatic logic [10:0] step_apply(input logic [10:0] s, input int k, input bit up);
      logic [4:0] c; logic [3:0] p; logic [1:0] b;
      c = s[4:0]; p = s[8:5]; b = s[10:9];
      if (up) begin
         case (k)
            0: c[2] = 1'b1;
            1: c[3] = 1'b1;
            2: c[4] = 1'b0;
            3: c[1] = 1'b0;
            4: c[0] = 1'b1;
            5: p = 4'h0;
            default: b = 2'b00;
         endcase
      end else begin
         case (k)
            0: b = 2'b11;
            1: p = 4'hF;
            2: c[1] = 1'b1;
            3: c[0] = 1'b0;
            4: c[4] = 1'b1;
            5: c[2] = 1'b0;
            default: c[3] = 1'b0;
         endcase
      end
      return {b, p, c};
   endfunction

   task automatic plan(input bit up, input int nsteps);
      for (int k = 0; k < nsteps; k++) begin
         logic [10:0] n;
         n = step_apply(exp_cur, k, up);
         if (n != exp_cur) exp_q.push_back(n);
         exp_cur = n;
      end
   endtask

   // monitor: every output change must be the next expected step (R2/R3, R11)
   logic [10:0] mon_last = {2'b11, 4'hF, 5'b10010};
   int          last_chg = -1000;

   always @(negedge clk) begin
      if (rst_n) begin
         logic [10:0] now;
         now = {prot, pdn, ctl};
         if (now != mon_last) begin
            if (exp_q.size() == 0) begin
               check(1'b0, "R2/R3 unexpected step", 32'(now), 32'(mon_last));
            end else begin
               logic [10:0] e;
               e = exp_q.pop_front();
               check(now == e, "R2/R3 step order", 32'(now), 32'(e));
            end
            check((cyc - last_chg) >= HOLD, "R11 step hold", 32'(cyc - last_chg), 32'(HOLD));
            last_chg = cyc;
            mon_last = now;
         end
      end
   end

   task automatic pulse_req(input bit on);
      @(negedge clk); req_vld = 1'b1; req_on = on;
      @(negedge clk); req_vld = 1'b0;
   endtask

   task automatic pulse_clr();
      @(negedge clk); clr_err = 1'b1;
      @(negedge clk); clr_err = 1'b0;
   endtask

   task automatic wait_for(input bit want_err, input int maxc, output bit seen);
      seen = 1'b0;
      for (int i = 0; i < maxc; i++) begin
         @(negedge clk);
         if (want_err ? err : done) begin
            seen = 1'b1;
            return;
         end
      end
   endtask

   task automatic quiet(input int n, input string req);
      bit any;
      any = 1'b0;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if (done) any = 1'b1;
      end
      check(!any, req, 32'(any), 32'd0);
   endtask

   // watchdog
   initial begin
      repeat (150000) @(posedge clk);
      nfail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
   end

   initial begin
      bit seen;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state
      check({prot, pdn, ctl} == 11'b11_1111_10010, "R1 reset outputs", 32'({prot, pdn, ctl}), 32'h7F2);
      check(state == 5'd0 && !busy && !err && !done, "R1 reset status",
            32'({state, busy, err, done}), 32'h0);

      // R2 + R4: power up with the second power-good late
      p2_hold = 1'b1;
      plan(1'b1, 7);
      pulse_req(1'b1);
      check(busy == 1'b1, "R10 busy after request", 32'(busy), 32'd1);
      repeat (25) @(negedge clk);
      check(ctl[4] == 1'b1 && ctl[3] == 1'b1, "R4 mismatch is not power-good",
            32'(ctl), 32'b11110);
      p2_hold = 1'b0;
      wait_for(1'b0, 200, seen);
      check(seen, "R2 power-up completes", 32'(seen), 32'd1);
      check(state == 5'd1 && !busy, "R10 on idle after up", 32'(state), 32'd1);
      @(negedge clk);
      check(done == 1'b0, "R10 done lasts one cycle", 32'(done), 32'd0);

      // R9: request for the present direction is ignored
      pulse_req(1'b1);
      quiet(10, "R9 same-direction request gives no done");
      check(state == 5'd1 && !busy, "R9 stays on idle", 32'(state), 32'd1);

      // R3 + R4: power down with the first power-good late; request while busy
      p1_hold = 1'b1;
      plan(1'b0, 7);
      pulse_req(1'b0);
      repeat (4) @(negedge clk);
      pulse_req(1'b1);
      repeat (44) @(negedge clk);
      check(busy == 1'b1 && ctl[2] == 1'b0, "R4 mismatch is not power-off",
            32'({busy, ctl}), 32'({1'b1, 5'b10010}));
      p1_hold = 1'b0;
      wait_for(1'b0, 200, seen);
      check(seen, "R3 power-down completes", 32'(seen), 32'd1);
      check(state == 5'd0, "R9 busy request ignored, off idle", 32'(state), 32'd0);

      // R7: timeout during power-up wait
      p2_hold = 1'b1;
      plan(1'b1, 2);
      pulse_req(1'b1);
      wait_for(1'b1, 300, seen);
      check(seen, "R7 power-up wait times out", 32'(seen), 32'd1);
      check(state == 5'd2 && !busy, "R7 error state", 32'({busy, state}), 32'd2);
      pulse_req(1'b0);
      quiet(8, "R9 request in error gives no done");
      check(state == 5'd2, "R9 request in error ignored", 32'(state), 32'd2);

      // R8: clear returns to off idle, retry succeeds
      pulse_clr();
      check(state == 5'd0 && !err, "R8 clear after failed up", 32'({err, state}), 32'd0);
      p2_hold = 1'b0;
      plan(1'b1, 7);
      pulse_req(1'b1);
      wait_for(1'b0, 300, seen);
      check(seen && state == 5'd1, "R8 retry of power-up", 32'(state), 32'd1);

      // R7 + R5: SRAM acknowledge stuck during power-down
      s_hold = 1'b1;
      plan(1'b0, 2);
      pulse_req(1'b0);
      wait_for(1'b1, 300, seen);
      check(seen && state == 5'd2, "R7 SRAM wait times out", 32'(state), 32'd2);
      pulse_clr();
      check(state == 5'd1 && !err, "R8 clear after failed down", 32'({err, state}), 32'd1);
      s_hold = 1'b0;
      plan(1'b0, 7);
      pulse_req(1'b0);
      wait_for(1'b0, 300, seen);
      check(seen && state == 5'd0, "R5 masked SRAM acknowledge only", 32'(state), 32'd0);

      // R5 + R6: instance with empty acknowledge and fence masks
      @(negedge clk); b_req_vld = 1'b1; b_req_on = 1'b1;
      @(negedge clk); b_req_vld = 1'b0;
      seen = 1'b0;
      for (int i = 0; i < 100 && !seen; i++) begin
         @(negedge clk);
         if (b_done) seen = 1'b1;
      end
      check(seen && b_state == 5'd1, "R5 SRAM wait skipped", 32'(b_state), 32'd1);
      check({b_prot, b_pdn, b_ctl} == {2'b00, 4'h0, 5'b01101}, "R6 no fence, domain up",
            32'({b_prot, b_pdn, b_ctl}), 32'({2'b00, 4'h0, 5'b01101}));
      @(negedge clk); b_req_vld = 1'b1; b_req_on = 1'b0;
      @(negedge clk); b_req_vld = 1'b0;
      seen = 1'b0;
      for (int i = 0; i < 100 && !seen; i++) begin
         @(negedge clk);
         if (b_done) seen = 1'b1;
      end
      check(seen && b_state == 5'd0 && b_prot == 2'b00, "R6 fence stays low on power-down",
            32'({b_prot, b_state}), 32'd0);
      check({b_pdn, b_ctl} == {4'hF, 5'b10010}, "R3 bare domain off",
            32'({b_pdn, b_ctl}), 32'({4'hF, 5'b10010}));

      repeat (5) @(negedge clk);
      check(exp_q.size() == 0, "R2/R3 all expected steps seen", 32'(exp_q.size()), 32'd0);

      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
   end

endmodule